// File: doc/BRIEF.md
# Paired-Instruction Fetch and Execute Sequencer

This block sequences a small accumulator machine whose 40-bit memory words each carry two 20-bit instructions. It owns the address register that drives every memory access and the data buffer register that every memory transfer passes through. It also owns a one-entry slot that holds the second instruction of a fetched word, the opcode register and the program counter. In straight-line code the second instruction of a word comes from the slot and needs no memory read. Jumps can target either instruction of a word.

The control is a single state machine with ten named states. `ST_FETCH` either takes the slot, when it holds an instruction (transition to `ST_EXEC`), or copies the program counter into the address register (transition to `ST_IREAD`). `ST_IREAD` issues the word read. `ST_IWAIT` captures the returned word in the buffer register. `ST_SPLIT` puts one half into the opcode and address registers and parks the other half in the slot. `ST_EXEC` decodes the opcode. From there a load or add goes to `ST_OREAD`, then `ST_OWAIT`, then `ST_ALU`, then back to `ST_FETCH`. A store goes to `ST_WRITE` and then to `ST_FETCH`. A jump, taken or not, returns to `ST_FETCH`. A halt enters `ST_HALT`, which is terminal. The attached memory is synchronous, with read data valid on the cycle after the read strobe.

Top module: `paired_fetch_seq`

## Requirements
- R1: When reset is released, the program counter, the accumulator and the slot-valid flag are cleared, `halted` is low and no memory strobe is active. The first memory read then targets word 0.
- R2: In a word, the instruction executed first occupies bits [39:20] and the second occupies bits [19:0]. In each instruction, bits [19:12] hold the opcode and bits [11:0] hold the operand address X.
- R3: In straight-line code, a word is read once and both of its instructions are executed. The second instruction is taken from the slot with no memory read, and the program counter then advances by one.
- R4: Opcode 0x01 loads M(X) into the accumulator.
- R5: Opcode 0x05 adds M(X) to the accumulator, in 40-bit two's complement with wrap-around.
- R6: Opcode 0x21 writes the accumulator to M(X) through the buffer register.
- R7: Opcode 0x0D jumps to word X. That word is read from memory, its first instruction runs and then its second.
- R8: Opcode 0x0E jumps to word X and runs only the second instruction of that word. The first instruction is discarded and execution continues at word X+1.
- R9: Opcodes 0x0F (first half) and 0x10 (second half) jump only when accumulator bit 39 is 0. Otherwise execution continues normally, including a second instruction already held in the slot.
- R10: A taken jump empties the slot, so the instruction paired with a jump is never executed.
- R11: Opcode 0x00 raises `halted`. No later memory access occurs and the accumulator holds its value.
- R12: Any other opcode leaves the accumulator and memory unchanged, and sequencing continues.
- R13: The read and write strobes are never active together, and every access uses `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Address of every memory access |
| mem_rd | output | 1 | Read strobe; data is expected the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 40 | Write data, taken from the buffer register |
| mem_rdata | input | 40 | Read data from the synchronous memory |
| acc_out | output | 40 | Accumulator value |
| halted | output | 1 | High once a halt has executed |

## Verification
A single step can resolve a conditional jump while the slot still holds the paired instruction. The jump decision and the slot flush then coincide, and a not-taken decision has to let the slot drain into the next fetch. The bench provokes this by placing conditional jumps in the first half of a word whose second half adds a known constant. It sweeps the accumulator over zero, small values of both signs and both 40-bit extremes. For each case it judges the final accumulator against sums computed in the bench, and it judges the memory-read count against the count that the taken or fallen-through path implies.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_HALT  = 8'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [OP_W-1:0] OPC_ADD   = 8'h05;
    localparam logic [OP_W-1:0] OPC_STOR  = 8'h21;
    localparam logic [OP_W-1:0] OPC_JMP_L = 8'h0D;
    localparam logic [OP_W-1:0] OPC_JMP_R = 8'h0E;
    localparam logic [OP_W-1:0] OPC_JGE_L = 8'h0F;
    localparam logic [OP_W-1:0] OPC_JGE_R = 8'h10;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_IREAD,
        ST_IWAIT,
        ST_SPLIT,
        ST_EXEC,
        ST_OREAD,
        ST_OWAIT,
        ST_ALU,
        ST_WRITE,
        ST_HALT
    } pf_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic split_word;
        logic take_ibr;
        logic jump_taken;
        logic jump_right;
        logic acc_load;
        logic acc_add;
    } pf_ctl_t;
endpackage

// File: rtl/pf_alu.sv
module pf_alu #(
    parameter int WORD_W = 40
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] operand,
    input  logic              load_sel,
    output logic [WORD_W-1:0] result,
    output logic              acc_neg
);
    always_comb begin
        if (load_sel) begin
            result = operand;
        end else begin
            result = acc + operand;
        end
    end

    assign acc_neg = acc[WORD_W-1];
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibr_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic              acc_neg,
    output pf_ctl_t           ctl,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted
);
    pf_state_e state_q, state_d;

    logic is_jump, is_cond, go_right;

    always_comb begin
        is_jump  = (opcode == OPC_JMP_L) || (opcode == OPC_JMP_R) ||
                   (opcode == OPC_JGE_L) || (opcode == OPC_JGE_R);
        is_cond  = (opcode == OPC_JGE_L) || (opcode == OPC_JGE_R);
        go_right = (opcode == OPC_JMP_R) || (opcode == OPC_JGE_R);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ibr_valid ? ST_EXEC : ST_IREAD;
            ST_IREAD: state_d = ST_IWAIT;
            ST_IWAIT: state_d = ST_SPLIT;
            ST_SPLIT: state_d = ST_EXEC;
            ST_EXEC: begin
                if (opcode == OPC_LOAD || opcode == OPC_ADD) begin
                    state_d = ST_OREAD;
                end else if (opcode == OPC_STOR) begin
                    state_d = ST_WRITE;
                end else if (opcode == OPC_HALT) begin
                    state_d = ST_HALT;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_OREAD: state_d = ST_OWAIT;
            ST_OWAIT: state_d = ST_ALU;
            ST_ALU:   state_d = ST_FETCH;
            ST_WRITE: state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl    = '0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                ctl.take_ibr    = ibr_valid;
                ctl.mar_from_pc = !ibr_valid;
            end
            ST_IREAD: mem_rd = 1'b1;
            ST_IWAIT: ctl.mbr_from_mem = 1'b1;
            ST_SPLIT: ctl.split_word = 1'b1;
            ST_EXEC: begin
                if (opcode == OPC_STOR) begin
                    ctl.mbr_from_acc = 1'b1;
                end
                if (is_jump) begin
                    ctl.jump_taken = !is_cond || !acc_neg;
                    ctl.jump_right = go_right;
                end
            end
            ST_OREAD: mem_rd = 1'b1;
            ST_OWAIT: ctl.mbr_from_mem = 1'b1;
            ST_ALU: begin
                ctl.acc_load = (opcode == OPC_LOAD);
                ctl.acc_add  = (opcode == OPC_ADD);
            end
            ST_WRITE: mem_wr = 1'b1;
            ST_HALT:  halted = 1'b1;
            default: begin
                halted = 1'b0;
            end
        endcase
    end

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));
endmodule

// File: rtl/pf_datapath.sv
module pf_datapath
    import pf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pf_ctl_t             ctl,
    input  logic [2*(OP_W+ADDR_W)-1:0] mem_rdata,
    output logic [ADDR_W-1:0]   mar,
    output logic [2*(OP_W+ADDR_W)-1:0] mbr,
    output logic [2*(OP_W+ADDR_W)-1:0] acc,
    output logic [OP_W-1:0]     opcode,
    output logic                ibr_valid,
    output logic                acc_neg
);
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int WORD_W  = 2 * INSTR_W;

    logic [ADDR_W-1:0]  pc_q;
    logic [INSTR_W-1:0] ibr_q;
    logic               enter_right_q;
    logic [WORD_W-1:0]  alu_res;

    logic [INSTR_W-1:0] first_half, second_half;
    assign first_half  = mbr[WORD_W-1:INSTR_W];
    assign second_half = mbr[INSTR_W-1:0];

    pf_alu #(.WORD_W(WORD_W)) u_alu (
        .acc      (acc),
        .operand  (mbr),
        .load_sel (ctl.acc_load),
        .result   (alu_res),
        .acc_neg  (acc_neg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q          <= '0;
            acc           <= '0;
            ibr_valid     <= 1'b0;
            enter_right_q <= 1'b0;
            mar           <= '0;
            mbr           <= '0;
            ibr_q         <= '0;
            opcode        <= '0;
        end else begin
            if (ctl.mar_from_pc) begin
                mar <= pc_q;
            end
            if (ctl.mbr_from_mem) begin
                mbr <= mem_rdata;
            end else if (ctl.mbr_from_acc) begin
                mbr <= acc;
            end
            if (ctl.split_word) begin
                if (enter_right_q) begin
                    opcode        <= second_half[INSTR_W-1:ADDR_W];
                    mar           <= second_half[ADDR_W-1:0];
                    pc_q          <= pc_q + 1'b1;
                    enter_right_q <= 1'b0;
                end else begin
                    opcode    <= first_half[INSTR_W-1:ADDR_W];
                    mar       <= first_half[ADDR_W-1:0];
                    ibr_q     <= second_half;
                    ibr_valid <= 1'b1;
                end
            end
            if (ctl.take_ibr) begin
                opcode    <= ibr_q[INSTR_W-1:ADDR_W];
                mar       <= ibr_q[ADDR_W-1:0];
                ibr_valid <= 1'b0;
                pc_q      <= pc_q + 1'b1;
            end
            if (ctl.jump_taken) begin
                pc_q          <= mar;
                ibr_valid     <= 1'b0;
                enter_right_q <= ctl.jump_right;
            end
            if (ctl.acc_load || ctl.acc_add) begin
                acc <= alu_res;
            end
        end
    end

    // R3
    ibr_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.take_ibr |-> ibr_valid);

    // R10
    jump_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump_taken |=> !ibr_valid);

    // R8
    right_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.split_word && enter_right_q) |=> !ibr_valid);
endmodule

// File: rtl/paired_fetch_seq.sv
module paired_fetch_seq
    import pf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mem_rd,
    output logic                          mem_wr,
    output logic [2*(OP_W+ADDR_W)-1:0]    mem_wdata,
    input  logic [2*(OP_W+ADDR_W)-1:0]    mem_rdata,
    output logic [2*(OP_W+ADDR_W)-1:0]    acc_out,
    output logic                          halted
);
    localparam int WORD_W = 2 * (OP_W + ADDR_W);

    pf_ctl_t           ctl;
    logic [OP_W-1:0]   opcode;
    logic              ibr_valid;
    logic              acc_neg;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;
    logic [WORD_W-1:0] acc;

    pf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ibr_valid (ibr_valid),
        .opcode    (opcode),
        .acc_neg   (acc_neg),
        .ctl       (ctl),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    pf_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mbr       (mbr),
        .acc       (acc),
        .opcode    (opcode),
        .ibr_valid (ibr_valid),
        .acc_neg   (acc_neg)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign acc_out   = acc;

    // R13
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc_out));
endmodule

// File: tb/paired_fetch_seq_bench.sv
`timescale 1ns/1ps
module paired_fetch_seq_bench;
    localparam logic [7:0] HALT = 8'h00, LOAD = 8'h01, ADD = 8'h05, STOR = 8'h21;
    localparam logic [7:0] JML = 8'h0D, JMR = 8'h0E, JGL = 8'h0F, JGR = 8'h10, BOGUS = 8'h7F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [39:0] mem_wdata, mem_rdata, acc_out;

    paired_fetch_seq u_paired_fetch_seq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .halted(halted)
    );

    logic [39:0] mem [64];
    int          rd_cnt, wr_cnt, clash_cnt;
    logic [11:0] first_rd_addr;
    logic        seen_rd;
    int          n_cmp = 0;
    int          n_bad = 0;

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
        if (!rst_n) begin
            rd_cnt <= 0; wr_cnt <= 0; clash_cnt <= 0; seen_rd <= 1'b0;
        end else begin
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if (mem_rd && mem_wr) clash_cnt <= clash_cnt + 1;
            if (mem_rd && !seen_rd) begin
                seen_rd <= 1'b1;
                first_rd_addr <= mem_addr;
            end
        end
    end

    task automatic check(string req, string what, logic [39:0] act, logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] ins(logic [7:0] op, int a);
        return {op, 12'(a)};
    endfunction

    function automatic logic [39:0] wd(logic [19:0] first, logic [19:0] second);
        return {first, second};
    endfunction

    task automatic prep();
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic run();
        int cyc;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 program did not halt: actual 0 expected 1");
        end
    endtask

    function automatic logic [39:0] sval(int i);
        case (i)
            0: return 40'h00_0000_0000;
            1: return 40'h00_0000_0001;
            2: return 40'hFF_FFFF_FFFF;
            3: return 40'h7F_FFFF_FFFF;
            default: return 40'h80_0000_0000;
        endcase
    endfunction

    initial begin
        #750000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [39:0] v0, v1, v2, v3, e;
        int r0, w0;

        // R1 reset state
        prep();
        repeat (3) @(negedge clk);
        check("R1", "acc in reset", acc_out, 40'h0);
        check("R1", "halted in reset", {39'h0, halted}, 40'h0);
        check("R1", "strobes in reset", {38'h0, mem_rd, mem_wr}, 40'h0);

        // R2 R3 R4 R5 R6: straight-line sum sweep
        for (int k = 0; k < 9; k++) begin
            prep();
            if (k == 8) begin
                v0 = 40'h7F_FFFF_FFFF; v1 = 40'h1; v2 = 40'h0; v3 = 40'h0;
            end else begin
                v0 = 40'(k * 123457);
                v1 = 40'(k * 9001 + 17);
                if (k % 2 == 1) v1 = -v1;
                v2 = 40'(k * 77 + 3);
                v3 = -40'(k * 5);
            end
            mem[0] = wd(ins(LOAD, 20), ins(ADD, 21));
            mem[1] = wd(ins(ADD, 22), ins(ADD, 23));
            mem[2] = wd(ins(STOR, 30), ins(HALT, 0));
            mem[20] = v0; mem[21] = v1; mem[22] = v2; mem[23] = v3;
            run();
            e = v0 + v1 + v2 + v3;
            check("R5", "sum in accumulator", acc_out, e);
            check("R6", "stored sum", mem[30], e);
            check("R3", "reads for 3 words + 4 operands", 40'(rd_cnt), 40'd7);
            check("R13", "rd/wr clash cycles", 40'(clash_cnt), 40'd0);
            if (k == 0) begin
                check("R1", "first read address", {28'h0, first_rd_addr}, 40'h0);
                check("R2", "operand field untouched", mem[20], v0);
            end
        end

        // R11 halt holds with no access
        r0 = rd_cnt; w0 = wr_cnt; e = acc_out;
        repeat (20) @(negedge clk);
        check("R11", "reads after halt", 40'(rd_cnt - r0), 40'd0);
        check("R11", "writes after halt", 40'(wr_cnt - w0), 40'd0);
        check("R11", "acc after halt", acc_out, e);

        // R8 R10: jump into second half, paired instruction flushed
        prep();
        mem[0] = wd(ins(JMR, 2), ins(ADD, 21));
        mem[1] = wd(ins(ADD, 22), ins(ADD, 22));
        mem[2] = wd(ins(ADD, 23), ins(LOAD, 20));
        mem[3] = wd(ins(ADD, 21), ins(HALT, 0));
        mem[20] = 40'd1000; mem[21] = 40'd30; mem[22] = 40'd500000; mem[23] = 40'd7;
        run();
        check("R8", "only second half run", acc_out, 40'd1030);
        check("R10", "reads with flush", 40'(rd_cnt), 40'd5);

        // R7: unconditional jump to first half
        prep();
        mem[0] = wd(ins(LOAD, 20), ins(JML, 2));
        mem[1] = wd(ins(ADD, 21), ins(HALT, 0));
        mem[2] = wd(ins(ADD, 22), ins(ADD, 23));
        mem[3] = wd(ins(HALT, 0), ins(HALT, 0));
        mem[20] = 40'd11; mem[21] = 40'd900; mem[22] = 40'd40; mem[23] = 40'd2;
        run();
        check("R7", "jump first half", acc_out, 40'd53);
        check("R7", "reads", 40'(rd_cnt), 40'd6);

        // R9: conditional jumps in second half, both targets
        for (int i = 0; i < 5; i++) begin
            for (int side = 0; side < 2; side++) begin
                logic taken;
                prep();
                v0 = sval(i);
                taken = !v0[39];
                mem[0] = wd(ins(LOAD, 20), ins(side == 0 ? JGL : JGR, 2));
                mem[1] = wd(ins(ADD, 21), ins(HALT, 0));
                mem[2] = wd(ins(ADD, 22), ins(ADD, 23));
                mem[3] = wd(ins(HALT, 0), ins(HALT, 0));
                mem[20] = v0; mem[21] = 40'd5; mem[22] = 40'd1000; mem[23] = 40'd70000;
                run();
                if (!taken) e = v0 + 40'd5;
                else if (side == 0) e = v0 + 40'd1000 + 40'd70000;
                else e = v0 + 40'd70000;
                check("R9", "conditional result", acc_out, e);
                check("R9", "conditional reads", 40'(rd_cnt),
                      (!taken) ? 40'd4 : (side == 0 ? 40'd6 : 40'd5));
            end
        end

        // R9 R10: conditional in first half with the second half buffered
        for (int i = 0; i < 5; i++) begin
            logic [39:0] s;
            prep();
            v0 = sval(i);
            s = v0 + 40'd3;
            mem[0] = wd(ins(LOAD, 20), ins(ADD, 21));
            mem[1] = wd(ins(JGL, 3), ins(ADD, 22));
            mem[2] = wd(ins(HALT, 0), ins(HALT, 0));
            mem[3] = wd(ins(ADD, 23), ins(HALT, 0));
            mem[20] = v0; mem[21] = 40'd3; mem[22] = 40'd11; mem[23] = 40'd500;
            run();
            e = s[39] ? s + 40'd11 : s + 40'd500;
            check("R10", "buffered half vs jump", acc_out, e);
            check("R9", "reads", 40'(rd_cnt), 40'd6);
        end

        // R12: unknown opcode has no effect
        prep();
        mem[0] = wd(ins(LOAD, 20), ins(BOGUS, 20));
        mem[1] = wd(ins(STOR, 31), ins(HALT, 0));
        mem[20] = 40'h12_3456_789A;
        run();
        check("R12", "acc after unknown op", acc_out, 40'h12_3456_789A);
        check("R12", "operand word unchanged", mem[20], 40'h12_3456_789A);
        check("R12", "single write", 40'(wr_cnt), 40'd1);
        check("R4", "loaded then stored", mem[31], 40'h12_3456_789A);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule